// File: doc/BRIEF.md
# Multi-View Inter-Thread FIFO Cell

This block is one memory-mapped queue cell shared by several hardware threads. A thread issues a request that carries its thread number, an address, a read/write flag and write data. A two-bit field of the address selects how the access treats the queue. The blocking view waits for data or space. The try view never waits. The bypass view looks at or patches the queue without moving it. The control view reads and writes the cell's tag word.

The cell answers every accepted request one cycle later. It either grants the request, with load data for reads, or reports a stall. A stalled request is parked in a per-thread slot and its bit is set in a waiting bitmap. The cell finishes that request by itself once the queue changes so that it can proceed. While it finishes a parked request, the cell drops `req_ready` for that cycle, so only one queue operation happens per cycle.

Top module: `mvfifo_cell`

## Requirements
- R1: After reset the queue is empty, the tag reports Empty=1 and Full=0, `wait_map` is all zeros, and neither `resp_valid` nor `resp_stall` is high.
- R2: A store through the blocking view (view code 2) or the try view (view code 3) appends to the queue, and a load through either view removes the oldest entry. The grant (`resp_valid`, `resp_tid`, `resp_rdata`) appears in the cycle after the request is accepted. Store grants return zero data.
- R3: A blocking-view load on an empty queue raises `resp_stall` in the next cycle and sets that thread's bit in `wait_map`. A thread whose bit is set issues no request.
- R4: A blocking-view store on a full queue stalls in the same way. The stored data is kept and pushed later.
- R5: The try view never stalls. A store to a full queue is granted and dropped, and a load from an empty queue is granted with zero data.
- R6: The bypass view (view code 0) never stalls and never changes Empty or Full. A load returns the oldest entry without removing it, or zero when the queue is empty. A store replaces the newest entry, and has no effect when the queue is empty.
- R7: The control view (view code 1) reads the tag: bit 0 Empty, bit 1 Full, bit 2 a type bit that always reads 1, and bits starting at 8 the occupancy. Writing 1 in bit 0 empties the queue. All other written bits have no effect.
- R8: Once the queue changes so that a parked request can complete, the cell serves that request in the following cycle. It holds `req_ready` low in that cycle, clears the thread's `wait_map` bit, and grants it one cycle later. If several parked requests can complete, the lowest thread number goes first, and only one is served per cycle.
- R9: Full is 1 exactly when the queue holds DEPTH entries, and Empty is 1 exactly when it holds none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted; low while a parked request is served |
| req_tid | input | TID_W | Requesting thread number |
| req_addr | input | ADDR_W | Access address; bits VIEW_LSB+1:VIEW_LSB select the view |
| req_write | input | 1 | 1 for store, 0 for load |
| req_wdata | input | DATA_W | Store data |
| resp_valid | output | 1 | Grant for `resp_tid` |
| resp_stall | output | 1 | Request of `resp_tid` was parked |
| resp_tid | output | TID_W | Thread the response belongs to |
| resp_rdata | output | DATA_W | Load data on a grant |
| wait_map | output | THREADS | One bit per thread with a parked request |

## Verification
The checker assumes that a thread whose `wait_map` bit is set issues no new request, and that no request is presented as accepted while `req_ready` is low. The bench keeps to both of these rules. It only issues requests from threads its model shows as not waiting, and it waits for `req_ready` before it drives a request. Random traffic sends a blocking-view access that would stall through the try view instead. Parked requests are created only in the directed sequences, where the model predicts every wake-up.

// File: rtl/mvfifo_pkg.sv
package mvfifo_pkg;
   typedef enum logic [1:0] {
      VIEW_BYPASS = 2'd0,
      VIEW_CTRL   = 2'd1,
      VIEW_SYNC   = 2'd2,
      VIEW_TRY    = 2'd3
   } view_e;

   localparam int TAG_EMPTY_BIT = 0;
   localparam int TAG_FULL_BIT  = 1;
   localparam int TAG_TYPE_BIT  = 2;
   localparam int TAG_COUNT_LSB = 8;
endpackage

// File: rtl/mvfifo_queue.sv
module mvfifo_queue #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   localparam int PW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic              ovr,
   input  logic              flush,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] head,
   output logic [CW-1:0]     count,
   output logic              empty,
   output logic              full
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("mvfifo_queue: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [PW-1:0]     rd_q, wr_q, newest;
   logic [CW-1:0]     cnt_q;

   assign newest = wr_q - PW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else if (push) begin
         wr_q  <= wr_q + PW'(1);
         cnt_q <= cnt_q + CW'(1);
      end else if (pop) begin
         rd_q  <= rd_q + PW'(1);
         cnt_q <= cnt_q - CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if ((push && !flush && wr_q == PW'(i)) || (ovr && newest == PW'(i)))
               mem_q[i] <= wdata;
         end
      end
   end

   assign head  = mem_q[rd_q];
   assign count = cnt_q;
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/mvfifo_waitmap.sv
module mvfifo_waitmap #(
   parameter int DATA_W  = 32,
   parameter int THREADS = 4,
   localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [TID_W-1:0]   set_tid,
   input  logic               set_write,
   input  logic [DATA_W-1:0]  set_data,
   input  logic               clr_en,
   input  logic [TID_W-1:0]   clr_tid,
   input  logic               q_empty,
   input  logic               q_full,
   output logic [THREADS-1:0] wait_map,
   output logic               wake_any,
   output logic [TID_W-1:0]   wake_tid,
   output logic               wake_write,
   output logic [DATA_W-1:0]  wake_data
);
   generate
      if (THREADS < 1) begin : g_bad_threads
         $error("mvfifo_waitmap: THREADS must be at least 1");
      end
   endgenerate

   logic [THREADS-1:0] wait_q, wr_q, elig;
   logic [DATA_W-1:0]  data_q [THREADS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_q <= '0;
         wr_q   <= '0;
         for (int t = 0; t < THREADS; t++) data_q[t] <= '0;
      end else begin
         for (int t = 0; t < THREADS; t++) begin
            if (set_en && set_tid == TID_W'(t)) begin
               wait_q[t] <= 1'b1;
               wr_q[t]   <= set_write;
               data_q[t] <= set_data;
            end else if (clr_en && clr_tid == TID_W'(t)) begin
               wait_q[t] <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      for (int t = 0; t < THREADS; t++)
         elig[t] = wait_q[t] && (wr_q[t] ? !q_full : !q_empty);
   end

   always_comb begin
      wake_tid = '0;
      for (int t = THREADS - 1; t >= 0; t--)
         if (elig[t]) wake_tid = TID_W'(t);
   end

   assign wake_any   = |elig;
   assign wake_write = wr_q[wake_tid];
   assign wake_data  = data_q[wake_tid];
   assign wait_map   = wait_q;
endmodule

// File: rtl/mvfifo_cell.sv
module mvfifo_cell
   import mvfifo_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int DEPTH    = 4,
   parameter int THREADS  = 4,
   parameter int ADDR_W   = 8,
   parameter int VIEW_LSB = 3,
   localparam int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1,
   localparam int CW      = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [TID_W-1:0]   req_tid,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic               req_write,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic               resp_valid,
   output logic               resp_stall,
   output logic [TID_W-1:0]   resp_tid,
   output logic [DATA_W-1:0]  resp_rdata,
   output logic [THREADS-1:0] wait_map
);
   generate
      if (VIEW_LSB + 2 > ADDR_W) begin : g_bad_view
         $error("mvfifo_cell: view field does not fit in the address");
      end
      if (TAG_COUNT_LSB + CW > DATA_W) begin : g_bad_tag
         $error("mvfifo_cell: tag word does not fit in DATA_W");
      end
   endgenerate

   view_e              view;
   logic               q_push, q_pop, q_ovr, q_flush;
   logic [DATA_W-1:0]  q_wdata, q_head;
   logic [CW-1:0]      q_count;
   logic               q_empty, q_full;
   logic               pend_set, wake_any, wake_write;
   logic [TID_W-1:0]   wake_tid;
   logic [DATA_W-1:0]  wake_data, tag_word;
   logic               grant_n, stall_n;
   logic [TID_W-1:0]   tid_n;
   logic [DATA_W-1:0]  rdata_n;
   logic               unused_addr;

   assign unused_addr = ^req_addr;
   assign view        = view_e'(req_addr[VIEW_LSB +: 2]);
   assign req_ready   = !wake_any;

   mvfifo_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push),
      .pop   (q_pop),
      .ovr   (q_ovr),
      .flush (q_flush),
      .wdata (q_wdata),
      .head  (q_head),
      .count (q_count),
      .empty (q_empty),
      .full  (q_full)
   );

   mvfifo_waitmap #(.DATA_W(DATA_W), .THREADS(THREADS)) u_wait (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_en     (pend_set),
      .set_tid    (req_tid),
      .set_write  (req_write),
      .set_data   (req_wdata),
      .clr_en     (wake_any),
      .clr_tid    (wake_tid),
      .q_empty    (q_empty),
      .q_full     (q_full),
      .wait_map   (wait_map),
      .wake_any   (wake_any),
      .wake_tid   (wake_tid),
      .wake_write (wake_write),
      .wake_data  (wake_data)
   );

   always_comb begin
      tag_word                 = '0;
      tag_word[TAG_EMPTY_BIT]  = q_empty;
      tag_word[TAG_FULL_BIT]   = q_full;
      tag_word[TAG_TYPE_BIT]   = 1'b1;
      tag_word[TAG_COUNT_LSB +: CW] = q_count;
   end

   always_comb begin
      q_push   = 1'b0;
      q_pop    = 1'b0;
      q_ovr    = 1'b0;
      q_flush  = 1'b0;
      q_wdata  = req_wdata;
      pend_set = 1'b0;
      grant_n  = 1'b0;
      stall_n  = 1'b0;
      tid_n    = req_tid;
      rdata_n  = '0;
      if (wake_any) begin
         grant_n = 1'b1;
         tid_n   = wake_tid;
         if (wake_write) begin
            q_push  = 1'b1;
            q_wdata = wake_data;
         end else begin
            q_pop   = 1'b1;
            rdata_n = q_head;
         end
      end else if (req_valid) begin
         grant_n = 1'b1;
         unique case (view)
            VIEW_SYNC: begin
               if (req_write ? q_full : q_empty) begin
                  grant_n  = 1'b0;
                  stall_n  = 1'b1;
                  pend_set = 1'b1;
               end else if (req_write) begin
                  q_push = 1'b1;
               end else begin
                  q_pop   = 1'b1;
                  rdata_n = q_head;
               end
            end
            VIEW_TRY: begin
               if (req_write) begin
                  q_push = !q_full;
               end else if (!q_empty) begin
                  q_pop   = 1'b1;
                  rdata_n = q_head;
               end
            end
            VIEW_BYPASS: begin
               if (req_write) q_ovr = !q_empty;
               else if (!q_empty) rdata_n = q_head;
            end
            VIEW_CTRL: begin
               if (req_write) q_flush = req_wdata[TAG_EMPTY_BIT];
               else rdata_n = tag_word;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_stall <= 1'b0;
         resp_tid   <= '0;
         resp_rdata <= '0;
      end else begin
         resp_valid <= grant_n;
         resp_stall <= stall_n;
         resp_tid   <= tid_n;
         resp_rdata <= rdata_n;
      end
   end
endmodule

// File: rtl/mvfifo_cell_checker.sv
module mvfifo_cell_checker #(
   parameter int DEPTH   = 4,
   parameter int THREADS = 4,
   localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
   localparam int CW     = $clog2(DEPTH + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic [TID_W-1:0]   req_tid,
   input logic [1:0]         view_bits,
   input logic               req_write,
   input logic               flush_bit,
   input logic               resp_valid,
   input logic               resp_stall,
   input logic [TID_W-1:0]   resp_tid,
   input logic [THREADS-1:0] wait_map,
   input logic [CW-1:0]      q_count,
   input logic               q_empty,
   input logic               q_full
);
   logic acc;
   assign acc = req_valid && req_ready;

   p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(q_empty && q_full));

   p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(DEPTH));

   p_no_req_while_waiting_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !wait_map[req_tid]);

   p_grant_stall_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(resp_valid && resp_stall));

   p_stall_marks_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
      resp_stall |-> wait_map[resp_tid]);

   p_try_never_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && view_bits == 2'd3) |=> (resp_valid && !resp_stall));

   p_bypass_keeps_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && view_bits == 2'd0) |=> ($stable(q_empty) && $stable(q_full) && resp_valid));

   p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && view_bits == 2'd1 && req_write && flush_bit) |=> q_empty);

   p_wake_grants_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> (resp_valid && !wait_map[resp_tid]));
endmodule

bind mvfifo_cell mvfifo_cell_checker #(.DEPTH(DEPTH), .THREADS(THREADS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_tid    (req_tid),
   .view_bits  (req_addr[VIEW_LSB +: 2]),
   .req_write  (req_write),
   .flush_bit  (req_wdata[0]),
   .resp_valid (resp_valid),
   .resp_stall (resp_stall),
   .resp_tid   (resp_tid),
   .wait_map   (wait_map),
   .q_count    (q_count),
   .q_empty    (q_empty),
   .q_full     (q_full)
);

// File: tb/mvfifo_cell_test.sv
`timescale 1ns/1ps
module mvfifo_cell_test;
   localparam int DATA_W = 32, DEPTH = 4, THREADS = 4, ADDR_W = 8, VIEW_LSB = 3;
   localparam int TID_W = 2;
   localparam int V_BYP = 0, V_CTRL = 1, V_SYNC = 2, V_TRY = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [TID_W-1:0] req_tid = '0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic req_ready, resp_valid, resp_stall;
   logic [TID_W-1:0] resp_tid;
   logic [DATA_W-1:0] resp_rdata;
   logic [THREADS-1:0] wait_map;

   always #2 clk = ~clk;

   mvfifo_cell #(.DATA_W(DATA_W), .DEPTH(DEPTH), .THREADS(THREADS),
                 .ADDR_W(ADDR_W), .VIEW_LSB(VIEW_LSB)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_tid(req_tid), .req_addr(req_addr), .req_write(req_write),
      .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_stall(resp_stall),
      .resp_tid(resp_tid), .resp_rdata(resp_rdata), .wait_map(wait_map));

   int nchk = 0, nfail = 0;
   logic [DATA_W-1:0] mq [DEPTH];
   int mcount = 0;
   logic [THREADS-1:0] mwait = '0, mwr = '0;
   logic [DATA_W-1:0] mdata [THREADS];

   task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] m_pop();
      logic [DATA_W-1:0] h = mq[0];
      for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i+1];
      mcount--;
      return h;
   endfunction

   function automatic void m_push(input logic [DATA_W-1:0] d);
      mq[mcount] = d;
      mcount++;
   endfunction

   function automatic logic [DATA_W-1:0] m_tag();
      return DATA_W'(mcount << 8) | 32'h4 | ((mcount == DEPTH) ? 32'h2 : 32'h0)
             | ((mcount == 0) ? 32'h1 : 32'h0);
   endfunction

   function automatic int m_wake();
      for (int t = 0; t < THREADS; t++)
         if (mwait[t] && (mwr[t] ? mcount < DEPTH : mcount > 0)) return t;
      return -1;
   endfunction

   task automatic op(input int tid, input int view, input bit wr,
                     input logic [DATA_W-1:0] d, input string req);
      bit exp_stall = 0;
      logic [DATA_W-1:0] exp_d = '0;
      case (view)
         V_SYNC: begin
            if (wr ? mcount == DEPTH : mcount == 0) begin
               exp_stall = 1; mwait[tid] = 1; mwr[tid] = wr; mdata[tid] = d;
            end else if (wr) m_push(d);
            else exp_d = m_pop();
         end
         V_TRY: begin
            if (wr) begin if (mcount < DEPTH) m_push(d); end
            else if (mcount > 0) exp_d = m_pop();
         end
         V_BYP: begin
            if (wr) begin if (mcount > 0) mq[mcount-1] = d; end
            else if (mcount > 0) exp_d = mq[0];
         end
         default: begin
            if (wr) begin if (d[0]) mcount = 0; end
            else exp_d = m_tag();
         end
      endcase
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_tid = TID_W'(tid); req_write = wr; req_wdata = d;
      req_addr = ADDR_W'((view << VIEW_LSB) | ($urandom & 7));
      @(negedge clk);
      req_valid = 0;
      check(resp_valid == !exp_stall && resp_stall == exp_stall, {req, " grant/stall"},
            {resp_valid, resp_stall}, {!exp_stall, exp_stall});
      check(resp_tid == TID_W'(tid), {req, " tid"}, resp_tid, tid);
      if (!exp_stall) check(resp_rdata == exp_d, {req, " data"}, resp_rdata, exp_d);
      check(wait_map == mwait, {req, " wait_map"}, wait_map, mwait);
      for (int w = m_wake(); w >= 0; w = m_wake()) begin
         logic [DATA_W-1:0] wd = '0;
         mwait[w] = 0;
         if (mwr[w]) m_push(mdata[w]); else wd = m_pop();
         check(!req_ready, "R8 ready low while serving", req_ready, 0);
         @(negedge clk);
         check(resp_valid && !resp_stall && resp_tid == TID_W'(w), "R8 wake grant tid",
               resp_tid, w);
         check(resp_rdata == wd, "R8 wake data", resp_rdata, wd);
         check(wait_map == mwait, "R8 wait bit cleared", wait_map, mwait);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED1234));
      for (int t = 0; t < THREADS; t++) mdata[t] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(!resp_valid && !resp_stall, "R1 no response after reset", {resp_valid, resp_stall}, 0);
      check(wait_map == '0, "R1 wait_map cleared", wait_map, 0);
      check(req_ready, "R1 ready after reset", req_ready, 1);
      op(0, V_CTRL, 0, 0, "R1 R7 reset tag");
      // R2 R9 fill through blocking view, check full tag
      for (int i = 0; i < DEPTH; i++) op(i % THREADS, V_SYNC, 1, 32'hA0 + i, "R2 sync push");
      op(1, V_CTRL, 0, 0, "R9 full tag");
      op(2, V_TRY, 1, 32'hDEAD, "R5 try push full dropped");
      op(3, V_BYP, 0, 0, "R6 bypass peek oldest");
      op(3, V_BYP, 1, 32'hBEEF, "R6 bypass overwrite newest");
      op(0, V_CTRL, 0, 0, "R6 flags unchanged");
      for (int i = 0; i < DEPTH; i++) op(1, V_TRY, 0, 0, "R2 pop order");
      op(2, V_TRY, 0, 0, "R5 try pop empty zero");
      op(2, V_BYP, 0, 0, "R6 bypass peek empty");
      op(2, V_BYP, 1, 32'h1234, "R6 bypass store empty ignored");
      op(2, V_CTRL, 0, 0, "R6 R9 still empty");
      // R3 R8 parked readers, lowest tid first
      op(2, V_SYNC, 0, 0, "R3 sync load empty stalls t2");
      op(1, V_SYNC, 0, 0, "R3 sync load empty stalls t1");
      op(0, V_SYNC, 1, 32'h111, "R8 push wakes t1");
      op(3, V_TRY, 1, 32'h222, "R8 push wakes t2");
      // R4 parked writer woken by pop
      for (int i = 0; i < DEPTH; i++) op(0, V_TRY, 1, 32'hC0 + i, "R4 fill");
      op(3, V_SYNC, 1, 32'h333, "R4 sync store full stalls");
      op(0, V_SYNC, 0, 0, "R4 pop wakes writer");
      op(1, V_CTRL, 0, 0, "R4 R9 full after wake");
      // R7 flush wakes parked writer; non-flush write ignored
      op(2, V_SYNC, 1, 32'h444, "R7 writer parks");
      op(1, V_CTRL, 1, 32'hFFFF_FFFE, "R7 write without bit0 ignored");
      op(1, V_CTRL, 1, 32'h1, "R7 flush wakes writer");
      op(1, V_CTRL, 0, 0, "R7 tag after flush");
      // random traffic
      for (int n = 0; n < 600; n++) begin
         int v = $urandom_range(3);
         bit w = $urandom_range(1);
         if (v == V_SYNC && (w ? mcount == DEPTH : mcount == 0)) v = V_TRY;
         if (v == V_CTRL && w && ($urandom_range(7) != 0)) w = 0;
         op($urandom_range(THREADS - 1), v, w, $urandom, "R2 random");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule